// File: doc/BRIEF.md
# Serial Configuration Chain Loader

This block writes a settings vector of any length into a chain of configuration registers spread across a chip. The chain is reached only through a serial data line and a shift clock, and the last stage of the chain comes back on a separate serial return line. The loader does not interpret the vector. It knows only the vector's length and the order in which data and clock must toggle.

When a load is requested, the loader latches the vector and a clock-divider setting. It then shifts the vector into the chain twice in a row, most-significant bit first. While the second copy goes in, the first copy comes out of the chain one bit at a time. Each returning bit is compared against the intended bit. Any difference sets a sticky error flag.

The return line has a weak pull-up. A broken or unconnected chain therefore reads back as ones, and the comparison catches it. A host drives `start` with a new vector, waits for `done`, and then inspects `err`.

Top module: `cfg_chain_loader`

## Requirements
- R1: After reset, and whenever no load is in progress, `sclk`, `sdo`, `busy`, `done` and `err` are all low. The exception is `err`, which keeps its value after a load (see R7).
- R2: During a load, `sclk` alternates between low and high phases. Each phase lasts H system clock cycles, where H is `half_div` latched at start, and a `half_div` of 0 is treated as 1. The first phase after start is low. `sclk` only rises while `busy` is high.
- R3: The vector is sent twice, most-significant bit first, for 2*VEC_W shift-clock periods in total. Each bit is placed on `sdo` at the start of its low phase and held unchanged through the following high phase.
- R4: `busy` goes high in the cycle after `start` is accepted and stays high for exactly 4*VEC_W*H cycles. In the cycle after `busy` falls, `done` is high for one cycle only.
- R5: The comparison samples `sdi` at the end of each high phase, for shift periods VEC_W-1 through 2*VEC_W-2 (counting from 0). Those samples are compared, in order, with vector bits VEC_W-1 down to 0. Any mismatch sets `err`.
- R6: A return line stuck high (all ones) sets `err`, unless the vector itself is all ones.
- R7: `err` keeps its value after the load completes. It is cleared only when the next load is accepted.
- R8: A `start` that arrives while `busy` is high is ignored. The running load keeps its latched vector, its latched divider setting and its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a load; accepted only when idle |
| vec_in | input | VEC_W | Settings vector, latched at start |
| half_div | input | DIV_W | System cycles per shift-clock half period (0 treated as 1) |
| sdi | input | 1 | Serial return from the chain's last stage |
| sclk | output | 1 | Shift clock to the chain; the chain samples on its rising edge |
| sdo | output | 1 | Serial data into the chain |
| busy | output | 1 | High while a two-pass load is running |
| done | output | 1 | One-cycle pulse when a load finishes |
| err | output | 1 | Sticky readback mismatch flag |

## Verification
The checker assumes two things about the inputs:
- `sdi` is produced by logic clocked from this block's own registered `sclk`, so it changes only at a rising shift edge and is settled well before the end of the high phase.
- `start` is a synchronous level that is sampled once per cycle.

The bench meets both by modelling the chain as a register clocked from `sclk`, with faults injected by forcing the return line high or holding one stage at zero. It drives `start` for one cycle between edges and changes the fault mode and divider only while idle. One `start` is deliberately issued in the middle of a load.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} ld_state_t;
endpackage

// File: rtl/cfgld_tick.sv
// Half-period timer: strobes once every `half` system cycles while running.
module cfgld_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tgl
);
  logic [DIV_W-1:0] cnt_q;

  assign tgl = run && (cnt_q == half - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (tgl)     cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/cfgld_tx.sv
// Transmit side: holds the latched vector, the bit index and the serial data output.
module cfgld_tx #(
  parameter int VEC_W = 64,
  localparam int CNT_W = $clog2(2*VEC_W+1),
  localparam int IDX_W = $clog2(VEC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [VEC_W-1:0] vec_in,
  input  logic             adv,
  input  logic             stop,
  output logic             sdo,
  output logic [CNT_W-1:0] idx,
  output logic             last,
  output logic [VEC_W-1:0] vec
);
  logic [CNT_W-1:0] idx_q;
  logic [VEC_W-1:0] vec_q;
  logic             sdo_q;
  logic [IDX_W-1:0] nxt_sel;
  int               pos;

  // bit position inside the vector for the next shift period (second pass wraps)
  always_comb begin
    pos = int'(idx_q) + 1;
    if (pos >= VEC_W) pos = pos - VEC_W;
    nxt_sel = IDX_W'(VEC_W - 1 - pos);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      vec_q <= '0;
      sdo_q <= 1'b0;
    end else if (load) begin
      idx_q <= '0;
      vec_q <= vec_in;
      sdo_q <= vec_in[VEC_W-1];
    end else if (adv) begin
      idx_q <= idx_q + CNT_W'(1);
      sdo_q <= vec_q[nxt_sel];
    end else if (stop) begin
      sdo_q <= 1'b0;
    end
  end

  assign sdo  = sdo_q;
  assign idx  = idx_q;
  assign vec  = vec_q;
  assign last = (idx_q == CNT_W'(2*VEC_W-1));
endmodule

// File: rtl/cfgld_cmp.sv
// Readback comparator: checks the returning first copy during the second pass.
module cfgld_cmp #(
  parameter int VEC_W = 64,
  localparam int CNT_W = $clog2(2*VEC_W+1),
  localparam int IDX_W = $clog2(VEC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             smp,
  input  logic [CNT_W-1:0] idx,
  input  logic [VEC_W-1:0] vec,
  input  logic             sdi,
  output logic             err
);
  logic             err_q;
  logic             win;
  logic [IDX_W-1:0] exp_sel;
  int               e;

  assign win = (idx >= CNT_W'(VEC_W-1)) && (idx <= CNT_W'(2*VEC_W-2));

  always_comb begin
    e = 2*VEC_W - 2 - int'(idx);
    exp_sel = IDX_W'(e);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                         err_q <= 1'b0;
    else if (smp && win && (sdi != vec[exp_sel])) err_q <= 1'b1;
  end

  assign err = err_q;
endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader
  import cfgld_pkg::*;
#(
  parameter int VEC_W = 64,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VEC_W-1:0] vec_in,
  input  logic [DIV_W-1:0] half_div,
  input  logic             sdi,
  output logic             sclk,
  output logic             sdo,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int CNT_W = $clog2(2*VEC_W+1);

  ld_state_t        st_q;
  logic [DIV_W-1:0] half_q;
  logic             sclk_q, busy_q, done_q;
  logic             start_ok, tgl, rise, fall, last;
  logic [CNT_W-1:0] bit_idx;
  logic [VEC_W-1:0] vec_q;

  assign start_ok = start && (st_q == ST_IDLE);
  assign rise     = tgl && !sclk_q;
  assign fall     = tgl &&  sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      half_q <= DIV_W'(1);
      sclk_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_RUN;
          busy_q <= 1'b1;
          sclk_q <= 1'b0;
          half_q <= (half_div == '0) ? DIV_W'(1) : half_div;
        end
        ST_RUN: begin
          if (rise) sclk_q <= 1'b1;
          if (fall) begin
            sclk_q <= 1'b0;
            if (last) begin
              st_q   <= ST_IDLE;
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  cfgld_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(st_q == ST_RUN), .half(half_q), .tgl(tgl)
  );

  cfgld_tx #(.VEC_W(VEC_W)) u_tx (
    .clk(clk), .rst(rst), .load(start_ok), .vec_in(vec_in),
    .adv(fall && !last), .stop(fall && last),
    .sdo(sdo), .idx(bit_idx), .last(last), .vec(vec_q)
  );

  cfgld_cmp #(.VEC_W(VEC_W)) u_cmp (
    .clk(clk), .rst(rst), .clr(start_ok), .smp(fall),
    .idx(bit_idx), .vec(vec_q), .sdi(sdi), .err(err)
  );

  assign sclk = sclk_q;
  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/cfg_chain_loader_chk.sv
module cfg_chain_loader_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic sclk,
  input logic sdo,
  input logic busy,
  input logic done,
  input logic err
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sclk && !sdo));
  // R2
  sclk_in_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> busy);
  // R3
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdo));
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));
  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(err));
  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !err);
  // R8
  start_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind cfg_chain_loader cfg_chain_loader_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .sclk(sclk), .sdo(sdo),
  .busy(busy), .done(done), .err(err)
);

// File: tb/cfg_chain_loader_tb.sv
module cfg_chain_loader_tb;
  localparam int N  = 12;
  localparam int DW = 4;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [N-1:0]  vec_in = '0;
  logic [DW-1:0] half_div = '0;
  logic          sdi, sclk, sdo, busy, done, err;

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";
  int    mode = 0;  // 0 good chain, 1 return line pulled high, 2 stage 5 stuck at zero

  always #5 clk = ~clk;

  cfg_chain_loader #(.VEC_W(N), .DIV_W(DW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .vec_in(vec_in), .half_div(half_div),
    .sdi(sdi), .sclk(sclk), .sdo(sdo), .busy(busy), .done(done), .err(err)
  );

  // behavioural chain
  logic [N-1:0] chain = '0;
  logic [N-1:0] chain_nx;
  always @(posedge sclk) begin
    chain_nx = {chain[N-2:0], sdo};
    if (mode == 2) chain_nx[5] = 1'b0;
    chain <= chain_nx;
  end
  assign sdi = (mode == 1) ? 1'b1 : chain[N-1];

  // reference model, advanced on each clock
  bit           act = 0, done_e = 0, err_e = 0;
  int           m = 0, hh = 1, g = 0;
  logic [N-1:0] rv = '0, tmp;

  always @(posedge clk) begin
    if (rst) begin
      act = 0; done_e = 0; err_e = 0; m = 0;
    end else begin
      done_e = 0;
      if (act) begin
        m++;
        if (m == 4*N*hh) begin
          act = 0; done_e = 1;
        end else if (m % (2*hh) == 0) begin
          g = m/(2*hh) - 1;
          if (g >= N-1 && g <= 2*N-2) begin
            tmp = rv >> (2*N-2-g);
            if (sdi != tmp[0]) err_e = 1;
          end
        end
      end else if (start) begin
        act = 1; m = 0; rv = vec_in; err_e = 0;
        hh = (half_div == 0) ? 1 : int'(half_div);
      end
    end
  end

  task automatic chk(string req, string nm, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) %s: got %b expected %b at %0t", req, tag, nm, got, exp, $time);
    end
  endtask

  logic exp_sdo;
  always @(negedge clk) begin
    tmp = rv >> (N-1-((m/(2*hh)) % N));
    exp_sdo = act ? tmp[0] : 1'b0;
    chk("R4", "busy", busy, act);
    chk("R4", "done", done, done_e);
    chk("R2", "sclk", sclk, act && ((m/hh) % 2 == 1));
    chk("R3", "sdo",  sdo,  exp_sdo);
    chk("R5", "err",  err,  err_e);
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic load(input logic [N-1:0] v, input int h, input int md);
    @(negedge clk);
    mode = md; vec_in = v; half_div = DW'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic expect_err(string req, logic e);
    chk(req, "err final", err, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1", "sclk reset", sclk, 1'b0);
    chk("R1", "sdo reset",  sdo,  1'b0);
    chk("R1", "busy reset", busy, 1'b0);
    chk("R1", "err reset",  err,  1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    tag = "R3";  load(12'hA5C, 2, 0); expect_err("R5", 1'b0);
    tag = "R2";  load(12'h3F0, 1, 0); expect_err("R5", 1'b0);
    tag = "R2";  load(12'h801, 0, 0); expect_err("R5", 1'b0); // half_div 0 behaves as 1
    tag = "R6";  load(12'h123, 3, 1); expect_err("R6", 1'b1);
    tag = "R7";
    repeat (10) @(negedge clk);
    chk("R7", "err held idle", err, 1'b1);
    @(negedge clk); mode = 0; vec_in = 12'h5A5; half_div = 4'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R7", "err cleared at start", err, 1'b0);
    while (!done) @(negedge clk);
    expect_err("R7", 1'b0);

    // R8: a second start in mid-load must not disturb the running load
    tag = "R8";
    begin
      int c = 0;
      @(negedge clk); mode = 0; vec_in = 12'hC3A; half_div = 4'd2; start = 1'b1;
      do begin
        @(negedge clk);
        c++;
        start = 1'b0;
        if (c == 20) begin vec_in = 12'h0FF; half_div = 4'd3; start = 1'b1; end
      end while (!done);
      chk("R8", "load length unchanged", (c == 4*N*2+1), 1'b1);
      start = 1'b0;
    end
    expect_err("R8", 1'b0);

    tag = "R5";  load(12'hFFF, 2, 2); expect_err("R5", 1'b1);
    tag = "R6";  load(12'hFFF, 1, 1); expect_err("R6", 1'b0);
    tag = "R5";  load(12'h6B2, 1, 0); expect_err("R5", 1'b0);
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (%s): got timeout expected completion", tag);
    summary();
    $finish;
  end
endmodule